// File: doc/BRIEF.md
# Receive Frame Ring Writer

This block sits between the receive side of an Ethernet MAC and a host. Bytes arrive one per cycle on a streaming input. A separate end strobe carries the frame's error flags and its address class. Each accepted frame is placed in a circular byte buffer. A 32-bit header carrying the frame's status and length is placed in front of the frame. The next frame then starts at the following 4-byte boundary. The host reads the buffer through a word-wide read port, reports how far it has consumed by writing a read-pointer register, and watches a buffer-empty flag.

The read-pointer register holds the host's true read offset minus 16, and the block adds 16 back before comparing. A frame is made visible only by its header write and the pointer update at its end strobe, so the host never sees a partial frame. A frame that does not fit in the space the host has freed is dropped and counted. The ring size is a base size (a parameter, `BASE_LOG2`) shifted left by a size index.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, the write offset is 0, the read-pointer register holds 16'hFFF0 (true read offset 0), `buf_empty` is 1, `rx_ok` and `rx_overflow` are 0, and `missed` is 0.
- R2: The ring holds (1 << BASE_LOG2) << k bytes, where k is `ring_size`, and the value 3 acts as 2. Every offset is taken modulo the ring size, so a frame body that runs past the last byte continues at offset 0.
- R3: When a frame is committed, the 32-bit word at its header offset holds the length in bits 31:16 and the status in bits 15:0. The length counts every byte received, FCS included. `rx_err` is ordered {bad symbol, runt, too long, CRC, alignment}, and the status layout is: bit 0 = 1 when `rx_err` is zero, bits 5:1 = `rx_err`, bit 13 = `rx_bcast`, bit 14 = `rx_own`, bit 15 = `rx_mcast`, all other bits 0.
- R4: Byte i of a frame (i from 0) is stored at ring offset header+4+i. Ring byte offset b appears in word b/4 of the read port, lane b%4 (bits 8*(b%4)+7 : 8*(b%4)), in little-endian order.
- R5: A committed frame of length L moves the write offset to (offset + L + 4 + 3) with bits 1:0 cleared, modulo the ring size. `rx_ok` is high for exactly the one cycle after the end strobe of a committed frame. End-strobe cycles carry no data byte.
- R6: The host writes (true read offset − 16) to the read-pointer register. `buf_empty` is 1 exactly when (register + 16) modulo the ring size equals the write offset.
- R7: The address filter uses `accept_mask` as follows. Bit 3 accepts frames with `rx_bcast`. Bit 2 accepts frames with `rx_mcast`. Bit 1 accepts frames with `rx_own`. Bit 0 accepts any frame that is neither broadcast nor multicast.
- R8: A frame with the runt flag needs mask bit 4 or bit 5. A frame with any other error flag needs mask bit 5. A rejected frame leaves the write offset, `rx_ok`, `rx_overflow` and `missed` unchanged.
- R9: The free space is ring size when empty, otherwise (true read offset − write offset) modulo ring size. An accepted frame is committed only if its rounded size (L+4+3 with bits 1:0 cleared) is strictly less than the free space. Otherwise it is dropped: `rx_overflow` pulses for one cycle, the 24-bit `missed` counter increments, the write offset is unchanged, and no byte at or beyond the free space is written.
- R10: During a frame, the word at the pending header offset keeps its previous contents until the end strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_size | input | 2 | Ring size index |
| accept_mask | input | 6 | Accept filter bits |
| rx_valid | input | 1 | Data byte strobe |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame strobe, qualifies the flags |
| rx_err | input | 5 | Error flags {bad symbol, runt, too long, CRC, alignment} |
| rx_bcast | input | 1 | Frame is broadcast |
| rx_mcast | input | 1 | Frame is multicast |
| rx_own | input | 1 | Destination matches own address |
| rdptr_we | input | 1 | Read-pointer register write strobe |
| rdptr_wdata | input | 16 | Read offset minus 16 |
| host_waddr | input | BASE_LOG2 | Word address for host reads |
| host_rdata | output | 32 | Buffer word at `host_waddr` |
| buf_empty | output | 1 | Read and write offsets are equal |
| rx_ok | output | 1 | Frame committed pulse |
| rx_overflow | output | 1 | Frame dropped for lack of space pulse |
| missed | output | 24 | Dropped frame count |
| wr_ptr | output | 16 | Current write offset (next header position) |

## Verification
The bench targets space exhaustion at its exact edge, where the rounded frame size equals the free space. A design that compared with less-or-equal there would let the write offset land on the read offset, and a full ring would then report empty. A frame that runs past the ring end, and a frame that follows a rejected or dropped one, check that a misplaced wrap or a stale byte count would corrupt stored bytes or the next header. Filter combinations with runt and CRC flags show whether runt frames are wrongly admitted under the error-accept bit alone, or wrongly refused. A header check taken mid-frame shows whether the header is written early.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int BASE_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           ring_size,
  input  logic [5:0]           accept_mask,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_data,
  input  logic                 rx_eof,
  input  logic [4:0]           rx_err,
  input  logic                 rx_bcast,
  input  logic                 rx_mcast,
  input  logic                 rx_own,
  input  logic                 rdptr_we,
  input  logic [15:0]          rdptr_wdata,
  input  logic [BASE_LOG2-1:0] host_waddr,
  output logic [31:0]          host_rdata,
  output logic                 buf_empty,
  output logic                 rx_ok,
  output logic                 rx_overflow,
  output logic [23:0]          missed,
  output logic [15:0]          wr_ptr
);
  localparam int WORDS = 1 << BASE_LOG2;

  logic [31:0] mem [WORDS];
  logic [15:0] capr, cnt, mask, rd, baddr;
  logic [16:0] ring, free_b, pos, need;
  logic [1:0]  sz;
  logic        spill, byte_ok, addr_ok, err_ok, accept, commit, drop;
  logic [15:0] status;

  assign sz      = ring_size[1] ? 2'd2 : ring_size;
  assign ring    = 17'd1 << (BASE_LOG2 + int'(sz));
  assign mask    = 16'(ring - 17'd1);
  assign rd      = (capr + 16'd16) & mask;
  assign free_b  = (rd == wr_ptr) ? ring : {1'b0, (rd - wr_ptr) & mask};
  assign pos     = {1'b0, cnt} + 17'd4;
  assign byte_ok = pos < free_b;
  assign baddr   = (wr_ptr + pos[15:0]) & mask;
  assign need    = ({1'b0, cnt} + 17'd7) & ~17'd3;

  assign addr_ok = (rx_bcast & accept_mask[3]) | (rx_mcast & accept_mask[2]) |
                   (rx_own & accept_mask[1]) | (~rx_bcast & ~rx_mcast & accept_mask[0]);
  assign err_ok  = (~|{rx_err[4], rx_err[2:0]} | accept_mask[5]) &
                   (~rx_err[3] | accept_mask[4] | accept_mask[5]);
  assign accept  = addr_ok & err_ok;
  assign commit  = rx_eof & accept & ~spill & (need < free_b);
  assign drop    = rx_eof & accept & ~commit;
  assign status  = {rx_mcast, rx_own, rx_bcast, 7'd0, rx_err, ~|rx_err};

  assign buf_empty  = rd == wr_ptr;
  assign host_rdata = mem[host_waddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr      <= '0;
      capr        <= 16'hFFF0;
      cnt         <= '0;
      spill       <= 1'b0;
      rx_ok       <= 1'b0;
      rx_overflow <= 1'b0;
      missed      <= '0;
    end else begin
      rx_ok       <= commit;
      rx_overflow <= drop;
      if (commit) wr_ptr <= 16'({1'b0, wr_ptr} + need) & mask;
      if (drop) missed <= missed + 24'd1;
      if (rdptr_we) capr <= rdptr_wdata;
      if (rx_eof) begin
        cnt   <= '0;
        spill <= 1'b0;
      end else if (rx_valid) begin
        if (~&cnt) cnt <= cnt + 16'd1;
        if (!byte_ok) spill <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && rx_valid && byte_ok)
      mem[BASE_LOG2'(baddr >> 2)][8*int'(baddr[1:0]) +: 8] <= rx_data;
    else if (rst_n && commit)
      mem[BASE_LOG2'(wr_ptr >> 2)] <= {cnt, status};
  end

  a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr[1:0] == 2'b00);
  a_r5_ok_moves: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ok |-> wr_ptr != $past(wr_ptr));
  a_r9_count: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |-> missed == $past(missed) + 24'd1);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |-> $stable(wr_ptr));
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_overflow |-> $stable(missed));
  a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ok && rx_overflow));
endmodule

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
  localparam int BL = 6;

  logic clk = 0, rst_n = 0;
  logic [1:0] ring_size = 0;
  logic [5:0] accept_mask = 0;
  logic rx_valid = 0, rx_eof = 0, rx_bcast = 0, rx_mcast = 0, rx_own = 0, rdptr_we = 0;
  logic [7:0] rx_data = 0;
  logic [4:0] rx_err = 0;
  logic [15:0] rdptr_wdata = 0;
  logic [BL-1:0] host_waddr = 0;
  logic [31:0] host_rdata;
  logic buf_empty, rx_ok, rx_overflow;
  logic [23:0] missed;
  logic [15:0] wr_ptr;

  rx_ring_writer #(.BASE_LOG2(BL)) u_dut (
    .clk(clk), .rst_n(rst_n), .ring_size(ring_size), .accept_mask(accept_mask),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof), .rx_err(rx_err),
    .rx_bcast(rx_bcast), .rx_mcast(rx_mcast), .rx_own(rx_own),
    .rdptr_we(rdptr_we), .rdptr_wdata(rdptr_wdata), .host_waddr(host_waddr),
    .host_rdata(host_rdata), .buf_empty(buf_empty), .rx_ok(rx_ok),
    .rx_overflow(rx_overflow), .missed(missed), .wr_ptr(wr_ptr));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int m_wp = 0, m_capr = 16'hFFF0, m_missed = 0, m_cnt = 0;
  bit m_spill = 0, m_ok = 0, m_ovf = 0;
  logic [7:0] mb [256];
  bit mv [256];
  bit done = 0;

  function automatic int ring_bytes();
    int k = (ring_size == 3) ? 2 : int'(ring_size);
    return (1 << BL) << k;
  endfunction

  function automatic int true_rd();
    return ((m_capr + 16) & 16'hFFFF) % ring_bytes();
  endfunction

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic bit model_accept();
    bit a, e;
    a = (rx_bcast && accept_mask[3]) || (rx_mcast && accept_mask[2]) ||
        (rx_own && accept_mask[1]) || (!rx_bcast && !rx_mcast && accept_mask[0]);
    e = (!(rx_err[4] || rx_err[2] || rx_err[1] || rx_err[0]) || accept_mask[5]) &&
        (!rx_err[3] || accept_mask[4] || accept_mask[5]);
    return a && e;
  endfunction

  task automatic step();
    @(posedge clk);
    begin
      int ring = ring_bytes();
      int rd = true_rd();
      int fr = (rd == m_wp) ? ring : (rd - m_wp + ring) % ring;
      m_ok = 0;
      m_ovf = 0;
      if (rx_valid) begin
        int p = m_cnt + 4;
        if (p < fr) begin
          mb[(m_wp + p) % ring] = rx_data;
          mv[(m_wp + p) % ring] = 1;
        end else m_spill = 1;
        m_cnt++;
      end
      if (rx_eof) begin
        int need = ((m_cnt + 7) / 4) * 4;
        if (model_accept()) begin
          if (!m_spill && need < fr) begin
            int st = (rx_err == 0 ? 1 : 0) | (int'(rx_err) << 1) | (int'(rx_bcast) << 13) |
                     (int'(rx_own) << 14) | (int'(rx_mcast) << 15);
            int hw = (m_cnt << 16) | st;
            for (int b = 0; b < 4; b++) begin
              mb[m_wp + b] = 8'(hw >> (8 * b));
              mv[m_wp + b] = 1;
            end
            m_wp = (m_wp + need) % ring;
            m_ok = 1;
          end else begin
            m_ovf = 1;
            m_missed = (m_missed + 1) % (1 << 24);
          end
        end
        m_cnt = 0;
        m_spill = 0;
      end
      if (rdptr_we) m_capr = int'(rdptr_wdata);
    end
    @(negedge clk);
    chk(buf_empty === (true_rd() == m_wp),
        $sformatf("R6 buf_empty act %0b exp %0b", buf_empty, true_rd() == m_wp));
    chk(wr_ptr === 16'(m_wp), $sformatf("R5 wr_ptr act %0d exp %0d", wr_ptr, m_wp));
    chk(rx_ok === m_ok, $sformatf("R5 rx_ok act %0b exp %0b", rx_ok, m_ok));
    chk(rx_overflow === m_ovf, $sformatf("R9 rx_overflow act %0b exp %0b", rx_overflow, m_ovf));
    chk(missed === 24'(m_missed), $sformatf("R9 missed act %0d exp %0d", missed, m_missed));
  endtask

  task automatic check_mem();
    for (int w = 0; w < ring_bytes() / 4; w++) begin
      bit any = 0, ok = 1;
      host_waddr = BL'(w);
      #1;
      for (int l = 0; l < 4; l++)
        if (mv[4 * w + l]) begin
          any = 1;
          if (host_rdata[8 * l +: 8] !== mb[4 * w + l]) ok = 0;
        end
      if (any) begin
        logic [31:0] e = 0;
        for (int l = 0; l < 4; l++) e[8 * l +: 8] = mb[4 * w + l];
        chk(ok, $sformatf("R2 R3 R4 word %0d act %h exp %h", w, host_rdata, e));
      end
    end
  endtask

  task automatic send(input int len, input int seed, input logic [4:0] err,
                      input bit bc, input bit mc, input bit own, input bit mid_chk);
    logic [31:0] saved;
    host_waddr = BL'(m_wp / 4);
    #1 saved = host_rdata;
    rx_err = err; rx_bcast = bc; rx_mcast = mc; rx_own = own;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1;
      rx_data = 8'(seed + i * 7);
      step();
      if (mid_chk && i == len - 1) begin
        host_waddr = BL'(m_wp / 4);
        #1 chk(host_rdata === saved,
               $sformatf("R10 header early act %h exp %h", host_rdata, saved));
      end
    end
    rx_valid = 0;
    rx_eof = 1;
    step();
    rx_eof = 0;
    step();
  endtask

  task automatic set_rd(input int off);
    rdptr_we = 1;
    rdptr_wdata = 16'(off - 16);
    step();
    rdptr_we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    m_wp = 0; m_capr = 16'hFFF0; m_missed = 0; m_cnt = 0;
    m_spill = 0; m_ok = 0; m_ovf = 0;
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(buf_empty === 1 && wr_ptr === 0 && rx_ok === 0 && rx_overflow === 0 && missed === 0,
        $sformatf("R1 reset state empty %0b wp %0d ok %0b ovf %0b missed %0d exp 1 0 0 0 0",
                  buf_empty, wr_ptr, rx_ok, rx_overflow, missed));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired, run did not complete");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 256; i++) mv[i] = 0;
    @(negedge clk);
    do_reset();
    accept_mask = 6'b000010;
    send(10, 3, 0, 0, 0, 1, 0);                // R3 R5 own unicast
    send(6, 9, 0, 1, 0, 0, 0);                 // R7 broadcast refused
    accept_mask = 6'b001010;
    send(5, 20, 0, 1, 0, 0, 1);                // R7 broadcast accepted, R10
    send(20, 40, 0, 0, 0, 1, 1);
    send(9, 60, 0, 0, 0, 1, 0);                // R9 no room
    check_mem();
    set_rd(28);
    send(30, 80, 0, 0, 0, 1, 1);               // R2 body wraps to 0
    check_mem();
    set_rd(m_wp);                              // R6 empty again
    send(3, 5, 0, 0, 1, 0, 0);                 // R7 multicast refused
    accept_mask = 6'b000110;
    send(3, 6, 0, 0, 1, 0, 0);                 // R7 multicast accepted
    send(7, 7, 0, 0, 0, 0, 0);                 // R7 foreign unicast refused
    accept_mask = 6'b000001;
    send(7, 8, 0, 0, 0, 0, 0);                 // R7 accept-all unicast
    set_rd(m_wp);
    send(4, 9, 5'b01000, 0, 0, 0, 0);          // R8 runt refused
    accept_mask = 6'b010001;
    send(4, 10, 5'b01000, 0, 0, 0, 0);         // R8 runt accepted
    send(12, 11, 5'b00010, 0, 0, 0, 0);        // R8 CRC refused under runt bit
    accept_mask = 6'b100001;
    send(12, 12, 5'b00010, 0, 0, 0, 0);        // R8 CRC accepted
    send(4, 13, 5'b01001, 0, 0, 0, 0);         // R8 runt via error bit
    check_mem();
    set_rd(m_wp);
    accept_mask = 6'b000010;
    send(60, 14, 0, 0, 0, 1, 0);               // R9 need == free, dropped
    send(56, 15, 0, 0, 0, 1, 0);               // R9 fits, four bytes left
    send(0, 0, 0, 0, 0, 1, 0);                 // R9 empty frame needs four, dropped
    check_mem();
    set_rd(m_wp);
    send(1, 16, 0, 0, 0, 1, 0);
    check_mem();

    ring_size = 1;                             // R2 larger ring
    do_reset();
    for (int k = 0; k < 6; k++) begin
      send(35 + 13 * k, 30 + k, 0, 0, 0, 1, k == 2);
      check_mem();
      set_rd(m_wp);
    end
    ring_size = 3;                             // R2 index 3 acts as 2
    do_reset();
    for (int k = 0; k < 5; k++) begin
      send(90 + 11 * k, 50 + k, 0, 0, 0, 1, 0);
      check_mem();
      set_rd(m_wp);
    end
    finish_up();
  end
endmodule